// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block sits between one processor and a shared snooping bus and keeps a small direct-mapped, write-back cache coherent with the other caches on that bus. Every line carries a tag, one data word and one of three coherence states: Modified (dirty, sole valid copy), Shared (clean, memory current) or Invalid. Processor accesses that can be served from the local line finish in the cycle they are presented. Any access that needs a bus transaction stalls until the bus grants it.

The controller also watches the transactions that other caches place on the bus. A remote read that hits a dirty local line makes the controller supply the word through a flush and drop the line to Shared. A remote exclusive read removes the local copy, flushing it first if it is dirty. Bus arbitration between caches and the memory behind the bus live outside this block.

Top module: `msi_coherence_ctrl`

## Requirements
- R1: After a synchronous reset every line is Invalid, so the first processor read of any address misses and issues a bus read, and a snoop to any address gets no flush.
- R2: A processor read whose tag matches a Shared or Modified line, and a processor write whose tag matches a Modified line, raise cpu_ready in the same cycle without raising bus_req. A read returns the line word on cpu_rdata and a write replaces the line word.
- R3: A processor read miss requests the bus with command 1 (bus read) and the full request address. In the granted cycle the word on bus_rdata is stored, the line becomes Shared, and the read then completes as a hit.
- R4: A processor write to a line that is Shared or Invalid (or holds another tag) requests the bus with command 2 (exclusive read) and moves the line to Modified holding the write data. The data returned on the bus is not used.
- R5: A snoop with command 2 whose tag matches a valid line invalidates it. If the line was Modified, snp_flush is raised in that cycle with the line word on snp_data.
- R6: A snoop with command 1 whose tag matches a Modified line raises snp_flush with the line word in that cycle, and the line becomes Shared. A snoop read of a Shared line causes no flush.
- R7: A miss to an index whose line is Modified with another tag first issues command 3 (write-back) carrying the old line address and word, and only then the fill for the new address.
- R8: A snoop with a non-matching tag, a snoop of an Invalid line, and a snoop with command 3 or 0 cause no flush and leave the line unchanged.
- R9: While snp_valid is high, a processor access whose index equals the snoop index is held off (cpu_ready low) in that cycle, and proceeds afterwards.
- R10: cpu_ready stays low while a bus request of this controller waits for bus_gnt. The bus_gnt cycle is the cycle in which that transaction takes effect.
- R11: The address is split with the low bits as line index and the remaining high bits as tag (3 index bits with the default of 8 lines).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 8 | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_ready | output | 1 | Access completes in this cycle |
| cpu_rdata | output | 16 | Read data, valid with cpu_ready on a read |
| bus_req | output | 1 | Request for a bus transaction |
| bus_cmd | output | 2 | Issued command: 1 read, 2 exclusive read, 3 write-back |
| bus_addr | output | 8 | Address of the issued command |
| bus_wdata | output | 16 | Write-back data for command 3 |
| bus_gnt | input | 1 | Grant; the issued transaction takes effect this cycle |
| bus_rdata | input | 16 | Word returned for a bus read in the grant cycle |
| snp_valid | input | 1 | A transaction from another cache is on the bus |
| snp_cmd | input | 2 | Command of the snooped transaction |
| snp_addr | input | 8 | Address of the snooped transaction |
| snp_flush | output | 1 | This cache supplies the snooped line |
| snp_data | output | 16 | Word supplied with snp_flush |

## Verification
The hardest case to reach is a miss that has to evict a dirty line, because the line must first be made Modified by an exclusive fill, then a second address with the same index and another tag must be read. The stimulus gets there by writing one address, then reading a neighbour eight words away, and it expects a write-back of the old word followed by the fill. A snoop that arrives in the same cycle as a hit to the same index is another narrow window. The bench drives both in one cycle and checks that the hit is deferred by exactly that cycle.

// File: rtl/msi_pkg.sv
package msi_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int LINES  = 8;
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_WB   = 2'd3
    } bus_cmd_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        line_st_e          st;
        logic [DATA_W-1:0] data;
    } line_t;

    function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W];
    endfunction

    function automatic logic line_match(input line_t l, input logic [ADDR_W-1:0] a);
        return (l.st != ST_I) && (l.tag == addr_tag(a));
    endfunction

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output line_t            rd_a,
    input  logic [IDX_W-1:0] rd_b_idx,
    output line_t            rd_b,
    input  logic             pr_we,
    input  logic [IDX_W-1:0] pr_idx,
    input  line_t            pr_line,
    input  logic             sn_we,
    input  logic [IDX_W-1:0] sn_idx,
    input  line_st_e         sn_st
);

    line_t lines_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                lines_q[g] <= '{tag: '0, st: ST_I, data: '0};
            end else if (pr_we && pr_idx == IDX_W'(g)) begin
                lines_q[g] <= pr_line;
            end else if (sn_we && sn_idx == IDX_W'(g)) begin
                lines_q[g].st <= sn_st;
            end
        end
    end

    assign rd_a = lines_q[rd_a_idx];
    assign rd_b = lines_q[rd_b_idx];

    // R1: out of reset both read ports see Invalid lines
    a_r1_reset_invalid: assert property (@(posedge clk)
        rst |=> (rd_a.st == ST_I && rd_b.st == ST_I));

    // R9: processor and snoop never update the same line in one cycle
    a_r9_no_update_clash: assert property (@(posedge clk) disable iff (rst)
        (pr_we && sn_we) |-> (pr_idx != sn_idx));

endmodule

// File: rtl/msi_snoop_side.sv
module msi_snoop_side
    import msi_pkg::*;
(
    input  logic              snp_valid,
    input  bus_cmd_e          snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  line_t             snp_line,
    output logic              flush,
    output logic [DATA_W-1:0] flush_data,
    output logic              upd_we,
    output line_st_e          upd_st
);

    logic hit;
    logic dirty;

    assign hit        = snp_valid && line_match(snp_line, snp_addr);
    assign dirty      = hit && (snp_line.st == ST_M);
    assign flush_data = snp_line.data;

    always_comb begin
        flush  = 1'b0;
        upd_we = 1'b0;
        upd_st = snp_line.st;
        if (hit) begin
            unique case (snp_cmd)
                CMD_RD: begin
                    flush  = dirty;
                    upd_we = dirty;
                    upd_st = ST_S;
                end
                CMD_RDX: begin
                    flush  = dirty;
                    upd_we = 1'b1;
                    upd_st = ST_I;
                end
                default: begin
                    flush  = 1'b0;
                    upd_we = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/msi_cpu_side.sv
module msi_cpu_side
    import msi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  line_t             cur_line,
    input  logic              snp_block,
    output logic              bus_req,
    output bus_cmd_e          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              pr_we,
    output line_t             pr_line
);

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_WBACK = 2'd1,
        PS_FETCH = 2'd2
    } pstate_e;

    pstate_e fsm_q, fsm_d;

    logic tag_eq;
    logic rd_hit;
    logic wr_hit;
    logic victim_dirty;

    assign tag_eq       = cur_line.tag == addr_tag(cpu_addr);
    assign rd_hit       = tag_eq && (cur_line.st != ST_I);
    assign wr_hit       = tag_eq && (cur_line.st == ST_M);
    assign victim_dirty = !tag_eq && (cur_line.st == ST_M);
    assign cpu_rdata    = cur_line.data;

    always_comb begin
        fsm_d     = fsm_q;
        cpu_ready = 1'b0;
        bus_req   = 1'b0;
        bus_cmd   = CMD_NONE;
        bus_addr  = cpu_addr;
        bus_wdata = cur_line.data;
        pr_we     = 1'b0;
        pr_line   = cur_line;
        unique case (fsm_q)
            PS_IDLE: begin
                if (cpu_req && !snp_block) begin
                    if (cpu_we ? wr_hit : rd_hit) begin
                        cpu_ready = 1'b1;
                        if (cpu_we) begin
                            pr_we        = 1'b1;
                            pr_line.data = cpu_wdata;
                        end
                    end else if (victim_dirty) begin
                        fsm_d = PS_WBACK;
                    end else begin
                        fsm_d = PS_FETCH;
                    end
                end
            end
            PS_WBACK: begin
                if (!victim_dirty) begin
                    fsm_d = PS_FETCH;
                end else begin
                    bus_req  = 1'b1;
                    bus_cmd  = CMD_WB;
                    bus_addr = {cur_line.tag, addr_idx(cpu_addr)};
                    if (bus_gnt) begin
                        pr_we      = 1'b1;
                        pr_line.st = ST_I;
                        fsm_d      = PS_FETCH;
                    end
                end
            end
            PS_FETCH: begin
                bus_req = 1'b1;
                bus_cmd = cpu_we ? CMD_RDX : CMD_RD;
                if (bus_gnt) begin
                    pr_we   = 1'b1;
                    pr_line = '{tag:  addr_tag(cpu_addr),
                                st:   cpu_we ? ST_M : ST_S,
                                data: cpu_we ? cpu_wdata : bus_rdata};
                    fsm_d   = PS_IDLE;
                end
            end
            default: fsm_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) fsm_q <= PS_IDLE;
        else     fsm_q <= fsm_d;
    end

    // R2: a completed access never coincides with a bus request
    a_r2_hit_no_bus: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !bus_req);

    // R10: completion only answers a pending request
    a_r10_ready_needs_req: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> cpu_req);

    // R7: a fill is never issued over a dirty line of another tag
    a_r7_fill_after_wb: assert property (@(posedge clk) disable iff (rst)
        (fsm_q == PS_FETCH) |-> !(cur_line.st == ST_M && cur_line.tag != addr_tag(cpu_addr)));

endmodule

// File: rtl/msi_coherence_ctrl.sv
module msi_coherence_ctrl
    import msi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_data
);

    line_t    cpu_line;
    line_t    snp_line;
    line_t    pr_line;
    logic     pr_we;
    logic     sn_we;
    line_st_e sn_st;
    bus_cmd_e issued_cmd;
    logic     snp_block;

    assign snp_block = snp_valid && (addr_idx(snp_addr) == addr_idx(cpu_addr));
    assign bus_cmd   = issued_cmd;

    msi_line_store u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (addr_idx(cpu_addr)),
        .rd_a     (cpu_line),
        .rd_b_idx (addr_idx(snp_addr)),
        .rd_b     (snp_line),
        .pr_we    (pr_we),
        .pr_idx   (addr_idx(cpu_addr)),
        .pr_line  (pr_line),
        .sn_we    (sn_we),
        .sn_idx   (addr_idx(snp_addr)),
        .sn_st    (sn_st)
    );

    msi_snoop_side u_snoop (
        .snp_valid  (snp_valid),
        .snp_cmd    (bus_cmd_e'(snp_cmd)),
        .snp_addr   (snp_addr),
        .snp_line   (snp_line),
        .flush      (snp_flush),
        .flush_data (snp_data),
        .upd_we     (sn_we),
        .upd_st     (sn_st)
    );

    msi_cpu_side u_cpu (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .cur_line  (cpu_line),
        .snp_block (snp_block),
        .bus_req   (bus_req),
        .bus_cmd   (issued_cmd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_gnt   (bus_gnt),
        .bus_rdata (bus_rdata),
        .pr_we     (pr_we),
        .pr_line   (pr_line)
    );

    // R8: a snooped write-back or idle command never draws a flush
    a_r8_wb_snoop_quiet: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && (snp_cmd == 2'd3 || snp_cmd == 2'd0)) |-> !snp_flush);

    // R9: a processor access colliding with a snoop index is held off
    a_r9_snoop_first: assert property (@(posedge clk) disable iff (rst)
        snp_block |-> !cpu_ready);

endmodule

// File: tb/msi_coherence_ctrl_test.sv
module msi_coherence_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [15:0] cpu_rdata;
    logic        bus_req;
    logic [1:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_gnt = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = '0;
    logic [7:0]  snp_addr = '0;
    logic        snp_flush;
    logic [15:0] snp_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int wait_cnt = 0;
    logic [15:0] mem [256];

    typedef struct {
        logic [1:0]  cmd;
        logic [7:0]  addr;
        logic [15:0] data;
        string       tag;
    } bx_t;
    bx_t         exp_bus [$];
    logic [15:0] exp_rd [$];
    string       exp_rd_tag [$];

    always #10 clk = ~clk;   // 50 MHz

    msi_coherence_ctrl uut (.*);

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_bus(input logic [1:0] c, input logic [7:0] a,
                            input logic [15:0] d, input string t);
        bx_t x;
        x.cmd = c; x.addr = a; x.data = d; x.tag = t;
        exp_bus.push_back(x);
    endtask

    // bus arbiter and memory model: grants after two waiting cycles
    always begin
        @(negedge clk);
        cycles++;
        if (bus_gnt) begin
            bus_gnt  = 1'b0;
            wait_cnt = 0;
        end else if (bus_req && !rst) begin
            wait_cnt++;
            if (wait_cnt == 2) begin
                chk(!cpu_ready, "R10", "ready while waiting for grant", 32'(cpu_ready), 0);
                if (exp_bus.size() == 0) begin
                    chk(1'b0, "R2", "unexpected bus request", 32'(bus_cmd), 0);
                end else begin
                    bx_t x;
                    x = exp_bus.pop_front();
                    chk(bus_cmd == x.cmd && bus_addr == x.addr, x.tag, "bus cmd/addr",
                        {22'd0, bus_cmd, bus_addr}, {22'd0, x.cmd, x.addr});
                    if (x.cmd == 2'd3) begin
                        chk(bus_wdata == x.data, x.tag, "write-back data",
                            32'(bus_wdata), 32'(x.data));
                        mem[bus_addr] = bus_wdata;
                    end
                end
                bus_rdata = mem[bus_addr];
                bus_gnt   = 1'b1;
            end
        end else begin
            wait_cnt = 0;
        end
    end

    // read monitor: pops the scoreboard on each completed read
    always begin
        @(negedge clk);
        #5;
        if (cpu_req && cpu_ready && !cpu_we) begin
            if (exp_rd.size() == 0) begin
                chk(1'b0, "R2", "unexpected read completion", 32'(cpu_rdata), 0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_rd.pop_front();
                t = exp_rd_tag.pop_front();
                chk(cpu_rdata == e, t, "read data", 32'(cpu_rdata), 32'(e));
            end
        end
    end

    task automatic cpu_op(input logic we, input logic [7:0] a, input logic [15:0] d,
                          input logic [15:0] e, input string t);
        logic got;
        got = 1'b0;
        if (!we) begin
            exp_rd.push_back(e);
            exp_rd_tag.push_back(t);
        end
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        while (!got) begin
            #5;
            got = cpu_ready;
            @(negedge clk);
        end
        cpu_req = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [7:0] a, input logic ef,
                         input logic [15:0] ed, input string t);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #5;
        chk(snp_flush == ef, t, "snoop flush", 32'(snp_flush), 32'(ef));
        if (ef) chk(snp_data == ed, t, "flush data", 32'(snp_data), 32'(ed));
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        chk(!cpu_ready && !bus_req && !snp_flush, "R1", "reset outputs",
            {29'd0, cpu_ready, bus_req, snp_flush}, 0);

        snoop(2'd2, 8'h40, 1'b0, '0, "R1");                 // all lines Invalid
        push_bus(2'd1, 8'h10, '0, "R3");
        cpu_op(1'b0, 8'h10, '0, 16'h1010, "R3");             // read miss, fill Shared
        cpu_op(1'b0, 8'h10, '0, 16'h1010, "R2");             // read hit in Shared
        push_bus(2'd2, 8'h10, '0, "R4");
        cpu_op(1'b1, 8'h10, 16'hA001, '0, "R4");             // write to Shared
        cpu_op(1'b1, 8'h10, 16'hB002, '0, "R2");             // write hit in Modified
        cpu_op(1'b0, 8'h10, '0, 16'hB002, "R2");             // read hit in Modified
        snoop(2'd1, 8'h10, 1'b1, 16'hB002, "R6");            // remote read of dirty line
        mem[8'h10] = 16'hB002;
        snoop(2'd1, 8'h10, 1'b0, '0, "R6");                  // now Shared: no flush
        snoop(2'd2, 8'h10, 1'b0, '0, "R5");                  // remote writer, clean copy
        mem[8'h10] = 16'hC003;
        push_bus(2'd1, 8'h10, '0, "R5");
        cpu_op(1'b0, 8'h10, '0, 16'hC003, "R5");             // invalidated: misses again
        snoop(2'd1, 8'h18, 1'b0, '0, "R8");                  // other tag, same index
        snoop(2'd3, 8'h10, 1'b0, '0, "R8");                  // write-back snoop ignored
        cpu_op(1'b0, 8'h10, '0, 16'hC003, "R8");             // still Shared, no bus
        push_bus(2'd2, 8'h23, '0, "R4");
        cpu_op(1'b1, 8'h23, 16'hD004, '0, "R4");             // write to Invalid
        snoop(2'd2, 8'h23, 1'b1, 16'hD004, "R5");            // dirty copy flushed
        mem[8'h23] = 16'hD004;
        push_bus(2'd1, 8'h23, '0, "R5");
        cpu_op(1'b0, 8'h23, '0, 16'hD004, "R5");
        push_bus(2'd2, 8'h05, '0, "R7");
        cpu_op(1'b1, 8'h05, 16'hF005, '0, "R7");
        push_bus(2'd3, 8'h05, 16'hF005, "R7");               // write-back before fill
        push_bus(2'd1, 8'h0D, '0, "R7");
        cpu_op(1'b0, 8'h0D, '0, 16'h100D, "R11");            // same index, other tag
        push_bus(2'd1, 8'h05, '0, "R7");
        cpu_op(1'b0, 8'h05, '0, 16'hF005, "R7");             // memory holds written word

        // R9: hit and snoop to the same index in one cycle
        exp_rd.push_back(16'hC003);
        exp_rd_tag.push_back("R9");
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h18;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h10;
        #5;
        chk(!cpu_ready, "R9", "ready during colliding snoop", 32'(cpu_ready), 0);
        @(negedge clk);
        snp_valid = 1'b0;
        #5;
        chk(cpu_ready, "R9", "ready after snoop", 32'(cpu_ready), 1);
        @(negedge clk);
        cpu_req = 1'b0;

        repeat (4) @(negedge clk);
        chk(exp_bus.size() == 0, "R3", "bus transactions left", exp_bus.size(), 0);
        chk(exp_rd.size() == 0, "R2", "reads left", exp_rd.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule